// File: doc/BRIEF.md
# Up/Down Wiper Stepping Controller

This block lets a host trim one of four 8-bit wiper positions with four simple pins instead of a serial bus transaction. Pulling the active-low select low opens a stepping session; every falling edge of the step clock then asks the wiper register bank to move the chosen wiper one position up or down. The direction pin sets which way, and a two-bit select picks the wiper. While a session is open, the block tells the neighbouring two-wire serial port to stay disabled.

Releasing the select ends the session. The level of the step clock at that moment decides what happens next. If the clock is high, the hardware write-protect is inactive and the status register's data-register select field is zero, the block issues a one-cycle store request. The register bank then copies the wiper into its level-0 nonvolatile register. In every other case the wiper simply keeps its new volatile position.

All pins are brought through two-flop synchronisers into the system clock domain, and edges are found there. The block reads back the four wiper values so that it never asks for a step past either end of the range. The register bank, the nonvolatile array and the resistor network sit outside this block.

Top module: `updn_wiper_ctrl`

## Requirements
- R1: `serial_en_o` is 1 while the select pin is high (released) and 0 while it is low; it is 1 after reset.
- R2: During a session, each falling edge of `step_clk_i` gives exactly one single-cycle request: `step_up_o` when `dir_up_i` is 1, `step_dn_o` when it is 0. The two are never high together.
- R3: `wsel_i` maps to the wiper index as follows: 00 gives index 0 (pot 0, wiper A), 11 gives 1 (pot 0, wiper B), 10 gives 2 (pot 1, wiper A) and 01 gives 3 (pot 1, wiper B). The index appears on `step_idx_o` and `store_idx_o`.
- R4: When the select rises while `step_clk_i` is high, `wp_n_i` is 1 and `dr_sel_i` is 00, `store_o` pulses for exactly one cycle with the index of the selected wiper.
- R5: With `wp_n_i` at 0 when the select rises, no store request is made.
- R6: When the select rises while `step_clk_i` is low, no store request is made and the wiper keeps its stepped value.
- R7: Any `dr_sel_i` value other than 00 when the select rises blocks the store request.
- R8: No increment is requested for a wiper at FFh and no decrement for a wiper at 00h, so the position saturates and never wraps.
- R9: Falling edges of `step_clk_i` while the select is high request no step.
- R10: Direction and wiper select may change within a session between clock edges; each edge uses the values present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_i | input | 1 | Active-low session select pin (asynchronous) |
| step_clk_i | input | 1 | Step clock pin; a falling edge steps (asynchronous) |
| dir_up_i | input | 1 | Direction pin, 1 = up, 0 = down (asynchronous) |
| wsel_i | input | 2 | Wiper select pins (asynchronous) |
| wp_n_i | input | 1 | Active-low hardware write protect (asynchronous) |
| dr_sel_i | input | 2 | Data-register select field of the status register |
| wiper_val_i | input | 32 | Current wiper values, wiper i at bits [8i+7:8i] |
| step_up_o | output | 1 | One-cycle increment request |
| step_dn_o | output | 1 | One-cycle decrement request |
| step_idx_o | output | 2 | Wiper index of the step request |
| store_o | output | 1 | One-cycle store-to-level-0 request |
| store_idx_o | output | 2 | Wiper index of the store request |
| serial_en_o | output | 1 | Enable for the two-wire serial port |

## Verification
Stepping is tried with runs of pulses in one direction on one wiper, with a walk through all four select codes, and with direction and select flipped mid-session. Together these separate a wrong direction, a wrong decode and a stale sampled value from one another, since only the addressed wiper may move. The release is tried in four forms: clock high with every permission granted, clock high with write-protect active, clock high with a nonzero register-select field, and clock low. This isolates each store condition. Wipers preset next to FFh and 00h, and clock edges sent while deselected, show that saturation holds and that idle edges are ignored.

// File: rtl/updn_pkg.sv
package updn_pkg;

  localparam int unsigned WIPERS = 4;
  localparam int unsigned IDX_W  = $clog2(WIPERS);

  typedef logic [IDX_W-1:0] widx_t;

  // Select-pin code to wiper index (non-binary pin order).
  function automatic widx_t sel_to_idx(input logic [1:0] sel);
    widx_t idx;
    case (sel)
      2'b00:   idx = widx_t'(0);
      2'b11:   idx = widx_t'(1);
      2'b10:   idx = widx_t'(2);
      default: idx = widx_t'(3);
    endcase
    return idx;
  endfunction

  // A step is allowed only if the wiper is not already at the end it moves to.
  function automatic logic step_ok(input logic up, input int unsigned val,
                                   input int unsigned top_val);
    if (up) return (val < top_val);
    return (val != 0);
  endfunction

endpackage

// File: rtl/updn_sync.sv
module updn_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/updn_edge.sv
module updn_edge #(
  parameter int unsigned WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/updn_session.sv
module updn_session
  import updn_pkg::*;
#(
  parameter int unsigned VAL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_s,
  input  logic             scl_s,
  input  logic             dir_s,
  input  logic             wp_s,
  input  logic             scl_fall,
  input  logic             cs_rise,
  input  widx_t            idx,
  input  logic [VAL_W-1:0] sel_val,
  input  logic [1:0]       dr_sel,
  output logic             step_up_o,
  output logic             step_dn_o,
  output widx_t            step_idx_o,
  output logic             store_o,
  output widx_t            store_idx_o,
  output logic             serial_en_o
);

  localparam int unsigned VAL_MAX = (1 << VAL_W) - 1;

  logic step_evt;
  logic may_move;
  logic store_evt;

  assign step_evt  = scl_fall && !cs_s;
  assign may_move  = step_ok(dir_s, int'(sel_val), VAL_MAX);
  assign store_evt = cs_rise && scl_s && wp_s && (dr_sel == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_up_o   <= 1'b0;
      step_dn_o   <= 1'b0;
      step_idx_o  <= '0;
      store_o     <= 1'b0;
      store_idx_o <= '0;
      serial_en_o <= 1'b1;
    end else begin
      step_up_o   <= step_evt && dir_s && may_move;
      step_dn_o   <= step_evt && !dir_s && may_move;
      if (step_evt) step_idx_o <= idx;
      store_o     <= store_evt;
      if (cs_rise) store_idx_o <= idx;
      serial_en_o <= cs_s;
    end
  end

endmodule

// File: rtl/updn_wiper_ctrl.sv
module updn_wiper_ctrl
  import updn_pkg::*;
#(
  parameter int unsigned VAL_W    = 8,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel_n_i,
  input  logic                      step_clk_i,
  input  logic                      dir_up_i,
  input  logic [1:0]                wsel_i,
  input  logic                      wp_n_i,
  input  logic [1:0]                dr_sel_i,
  input  logic [WIPERS*VAL_W-1:0]   wiper_val_i,
  output logic                      step_up_o,
  output logic                      step_dn_o,
  output logic [IDX_W-1:0]          step_idx_o,
  output logic                      store_o,
  output logic [IDX_W-1:0]          store_idx_o,
  output logic                      serial_en_o
);

  localparam int unsigned PIN_W = 6;
  localparam logic [PIN_W-1:0] PIN_RST = 6'b10_0000;

  logic [PIN_W-1:0] pin_raw, pin_s;
  logic cs_s, scl_s, dir_s, wp_s;
  logic [1:0] sel_s;
  logic [1:0] ev_rise, ev_fall;
  logic cs_rise_w, scl_fall_w;
  widx_t idx_w;
  logic [VAL_W-1:0] wv [WIPERS];
  logic [VAL_W-1:0] sel_val;

  assign pin_raw = {sel_n_i, step_clk_i, dir_up_i, wsel_i, wp_n_i};

  updn_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STG), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_raw), .q_o(pin_s)
  );

  assign {cs_s, scl_s, dir_s, sel_s, wp_s} = pin_s;

  updn_edge #(.WIDTH(2), .RST_VAL(2'b10)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i({cs_s, scl_s}),
    .rise_o(ev_rise), .fall_o(ev_fall)
  );

  assign cs_rise_w  = ev_rise[1];
  assign scl_fall_w = ev_fall[0];
  assign idx_w      = sel_to_idx(sel_s);

  for (genvar w = 0; w < WIPERS; w++) begin : g_unpack
    assign wv[w] = wiper_val_i[w*VAL_W +: VAL_W];
  end

  assign sel_val = wv[idx_w];

  updn_session #(.VAL_W(VAL_W)) u_sess (
    .clk(clk), .rst_n(rst_n),
    .cs_s(cs_s), .scl_s(scl_s), .dir_s(dir_s), .wp_s(wp_s),
    .scl_fall(scl_fall_w), .cs_rise(cs_rise_w),
    .idx(idx_w), .sel_val(sel_val), .dr_sel(dr_sel_i),
    .step_up_o(step_up_o), .step_dn_o(step_dn_o), .step_idx_o(step_idx_o),
    .store_o(store_o), .store_idx_o(store_idx_o), .serial_en_o(serial_en_o)
  );

endmodule

// File: rtl/updn_wiper_chk.sv
module updn_wiper_chk #(
  parameter int unsigned VAL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             serial_en_o,
  input logic             step_up_o,
  input logic             step_dn_o,
  input logic             store_o,
  input logic [1:0]       dr_sel_i,
  input logic             wp_s,
  input logic             scl_s,
  input logic [VAL_W-1:0] sel_val
);

  AST_STEP_LOCKS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up_o || step_dn_o) |-> !serial_en_o); // R1

  AST_STEP_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up_o && step_dn_o)); // R2

  AST_STORE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    store_o |-> serial_en_o); // R4

  AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    store_o |=> !store_o); // R4

  AST_STORE_NEEDS_WP: assert property (@(posedge clk) disable iff (!rst_n)
    store_o |-> $past(wp_s)); // R5

  AST_STORE_NEEDS_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    store_o |-> $past(scl_s)); // R6

  AST_STORE_NEEDS_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
    store_o |-> ($past(dr_sel_i) == 2'b00)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    step_up_o |-> ($past(sel_val) != {VAL_W{1'b1}})); // R8

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn_o |-> ($past(sel_val) != '0)); // R8

endmodule

bind updn_wiper_ctrl updn_wiper_chk #(.VAL_W(VAL_W)) u_chk (.*);

// File: tb/updn_wiper_ctrl_tb.sv
module updn_wiper_ctrl_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, sel_n, sclk, dir_up, wp_n;
  logic [1:0] wsel, dr_sel;
  logic [31:0] wval;
  logic step_up_o, step_dn_o, store_o, serial_en_o;
  logic [1:0] step_idx_o, store_idx_o;

  logic [7:0] wreg [4];
  int expv [4];
  int checks = 0, errors = 0;
  int st_cnt = 0, st_cyc = 0, up_cnt = 0, dn_cnt = 0;
  logic [1:0] st_last = '0;
  logic done = 1'b0;

  assign wval = {wreg[3], wreg[2], wreg[1], wreg[0]};

  updn_wiper_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .step_clk_i(sclk),
    .dir_up_i(dir_up), .wsel_i(wsel), .wp_n_i(wp_n), .dr_sel_i(dr_sel),
    .wiper_val_i(wval), .step_up_o(step_up_o), .step_dn_o(step_dn_o),
    .step_idx_o(step_idx_o), .store_o(store_o), .store_idx_o(store_idx_o),
    .serial_en_o(serial_en_o)
  );

  // Register-bank model: plain wrapping arithmetic, so a bad request shows up.
  logic st_prev = 1'b0;
  always @(posedge clk) begin
    if (step_up_o) begin wreg[step_idx_o] <= wreg[step_idx_o] + 8'd1; up_cnt <= up_cnt + 1; end
    if (step_dn_o) begin wreg[step_idx_o] <= wreg[step_idx_o] - 8'd1; dn_cnt <= dn_cnt + 1; end
    if (store_o) begin
      st_cyc <= st_cyc + 1;
      st_last <= store_idx_o;
      if (!st_prev) st_cnt <= st_cnt + 1;
    end
    st_prev <= store_o;
  end

  function automatic int sat_up(int v); return (v >= 255) ? 255 : v + 1; endfunction
  function automatic int sat_dn(int v); return (v <= 0) ? 0 : v - 1; endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic chk_regs(string tag);
    for (int i = 0; i < 4; i++) chk(int'(wreg[i]) == expv[i], tag, wreg[i], expv[i]);
  endtask

  task automatic preset(int i, int v);
    wreg[i] = 8'(v); expv[i] = v;
  endtask

  task automatic pulse(); sclk = 1'b1; idle(6); sclk = 1'b0; idle(6); endtask

  task automatic open_sess(logic [1:0] s, logic up);
    sclk = 1'b0; wsel = s; dir_up = up; idle(2); sel_n = 1'b0; idle(6);
  endtask

  task automatic close_sess(logic clk_hi);
    if (clk_hi) begin sclk = 1'b1; idle(6); end
    sel_n = 1'b1; idle(6); sclk = 1'b0; idle(6);
  endtask

  task automatic t_reset();
    chk(serial_en_o == 1'b1, "R1 reset serial_en", serial_en_o, 1);
    chk(!step_up_o && !step_dn_o && !store_o, "R2 reset no request", 1, 0);
  endtask

  task automatic t_lock();
    open_sess(2'b00, 1'b1);
    chk(serial_en_o == 1'b0, "R1 locked in session", serial_en_o, 0);
    close_sess(1'b0);
    chk(serial_en_o == 1'b1, "R1 released", serial_en_o, 1);
  endtask

  task automatic t_inc_dec();
    preset(0, 10); preset(1, 50);
    open_sess(2'b00, 1'b1);
    repeat (3) begin pulse(); expv[0] = sat_up(expv[0]); end
    close_sess(1'b0);
    chk_regs("R2 increment wiper 0");
    open_sess(2'b11, 1'b0);
    repeat (2) begin pulse(); expv[1] = sat_dn(expv[1]); end
    close_sess(1'b0);
    chk_regs("R2 decrement wiper 1");
  endtask

  task automatic t_decode();
    logic [1:0] codes [4] = '{2'b00, 2'b11, 2'b10, 2'b01};
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 4; i++) preset(i, 100);
      open_sess(codes[k], 1'b1);
      pulse();
      close_sess(1'b0);
      expv[k] = 101;
      chk_regs("R3 select decode");
    end
  endtask

  task automatic t_store_ok();
    int c0 = st_cnt, y0 = st_cyc;
    wp_n = 1'b1; dr_sel = 2'b00;
    open_sess(2'b10, 1'b1);
    close_sess(1'b1);
    chk(st_cnt == c0 + 1, "R4 store issued", st_cnt - c0, 1);
    chk(st_cyc == y0 + 1, "R4 one-cycle store", st_cyc - y0, 1);
    chk(st_last == 2'd2, "R4 R3 store index", st_last, 2);
  endtask

  task automatic t_store_wp();
    int c0 = st_cnt;
    wp_n = 1'b0; dr_sel = 2'b00;
    open_sess(2'b01, 1'b1);
    close_sess(1'b1);
    chk(st_cnt == c0, "R5 write-protect blocks store", st_cnt - c0, 0);
    wp_n = 1'b1;
  endtask

  task automatic t_no_store_low();
    int c0 = st_cnt;
    preset(3, 20);
    open_sess(2'b01, 1'b1);
    pulse(); expv[3] = 21;
    close_sess(1'b0);
    chk(st_cnt == c0, "R6 clock low gives no store", st_cnt - c0, 0);
    chk_regs("R6 volatile value kept");
  endtask

  task automatic t_store_drsel();
    int c0 = st_cnt;
    for (int v = 1; v < 4; v++) begin
      dr_sel = 2'(v);
      open_sess(2'b00, 1'b1);
      close_sess(1'b1);
    end
    chk(st_cnt == c0, "R7 row select blocks store", st_cnt - c0, 0);
    dr_sel = 2'b00;
  endtask

  task automatic t_sat();
    preset(2, 254);
    open_sess(2'b10, 1'b1);
    repeat (3) begin pulse(); expv[2] = sat_up(expv[2]); end
    close_sess(1'b0);
    chk_regs("R8 saturate at top");
    preset(0, 1);
    open_sess(2'b00, 1'b0);
    repeat (3) begin pulse(); expv[0] = sat_dn(expv[0]); end
    close_sess(1'b0);
    chk_regs("R8 saturate at bottom");
  endtask

  task automatic t_idle_clk();
    int u0 = up_cnt, d0 = dn_cnt;
    dir_up = 1'b1; wsel = 2'b00;
    repeat (4) pulse();
    chk(up_cnt == u0 && dn_cnt == d0, "R9 edges ignored when released",
        (up_cnt - u0) + (dn_cnt - d0), 0);
  endtask

  task automatic t_midchange();
    for (int i = 0; i < 4; i++) preset(i, 80);
    open_sess(2'b00, 1'b1);
    pulse(); expv[0] = 81;
    sclk = 1'b1; idle(3); dir_up = 1'b0; wsel = 2'b10; idle(3); sclk = 1'b0; idle(6);
    expv[2] = 79;
    dir_up = 1'b1; wsel = 2'b01; idle(3);
    pulse(); expv[3] = 81;
    close_sess(1'b0);
    chk_regs("R10 mid-session changes");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin wreg[i] = '0; expv[i] = 0; end
    rst_n = 1'b0; sel_n = 1'b1; sclk = 1'b0; dir_up = 1'b0;
    wsel = 2'b00; wp_n = 1'b1; dr_sel = 2'b00;
    idle(5); rst_n = 1'b1; idle(5);
    t_reset();
    t_lock();
    t_inc_dec();
    t_decode();
    t_store_ok();
    t_store_wp();
    t_no_store_low();
    t_store_drsel();
    t_sat();
    t_idle_clk();
    t_midchange();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule